// File: doc/BRIEF.md
# Two-Channel Staged DAC Code Register

This block sits between an 8-bit host write port and two 12-bit digital-to-analog converters. Each channel owns a pair of byte addresses. A write to the lower address of the pair only parks the eight least significant code bits in a staging register. A write to the upper address commits a full 12-bit code to the channel's output latch. That code is built from the four bits carried by the upper write and the staged byte. The converter input therefore never shows a half-updated code.

Because the commit always uses whatever byte is staged at that moment, the order of the writes matters. Software must stage the low byte first and then commit with the high byte. If only the high byte is written, the new upper nibble is paired with the old staged byte. A low byte written after the commit waits silently until the next commit. The two channels do not share any state.

Top module: `dac_dbuf_regs`

## Requirements
- R1: After reset, both 12-bit codes and both staged low bytes are zero, and neither commit pulse is high.
- R2: Address 4 stages channel 0's low byte and address 5 commits channel 0. Address 6 stages channel 1's low byte and address 7 commits channel 1. Writes to any other address change nothing.
- R3: A write to a staging address never changes either output code.
- R4: A commit write loads the code {wdata[3:0], staged low byte}. Data bits 7..4 of a commit write are ignored.
- R5: A commit made without a fresh low-byte write uses the low byte that was staged earlier.
- R6: A low byte written after a commit reaches the output only at the next commit of that channel.
- R7: A write addressed to one channel never changes the other channel's code or staged byte.
- R8: The code changes on the first clock edge that samples the commit strobe. That channel's commit pulse is high for exactly the one following cycle, and a code never changes without its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe, one per clock cycle |
| addr_i | input | 4 | Byte offset of the write |
| wdata_i | input | 8 | Write data |
| code0_o | output | 12 | Channel 0 DAC code |
| code1_o | output | 12 | Channel 1 DAC code |
| commit_o | output | 2 | One-cycle commit pulse per channel |

## Verification
A wrong staged byte stays hidden until the next commit of its channel. It then shows up in the low eight bits of that code, one cycle after the commit strobe. A faulty address decode or cross-channel coupling shows up at once, either as a code change without a commit pulse or as a change on the wrong channel. The bench sweeps every address with several data patterns and compares both codes after every write against a model kept in the bench.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned HI_W    = CODE_W - BUS_W;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned N_CH    = 2;
  localparam logic [ADDR_W-1:0] BASE_OFS = 4'd4;
endpackage

// File: rtl/dac_addr_dec.sv
module dac_addr_dec
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned NCH = N_CH
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NCH-1:0]    lo_we_o,
  output logic [NCH-1:0]    hi_we_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_OFS + 2*c);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_OFS + 2*c + 1);
    assign lo_we_o[c] = wr_en_i && (addr_i == LO_A);
    assign hi_we_o[c] = wr_en_i && (addr_i == HI_A);
  end
endmodule

// File: rtl/dac_chan_latch.sv
module dac_chan_latch
  import dac_dbuf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic              commit_o
);
  logic [BUS_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      code_o   <= '0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= hi_we_i;
      if (lo_we_i) lo_q <= wdata_i;
      // commit uses the byte staged before this edge
      if (hi_we_i) code_o <= {wdata_i[HI_W-1:0], lo_q};
    end
  end

  // R3 R8
  code_no_silent_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> commit_o);
  // R8
  commit_follows_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> commit_o);
  // R4 R5
  commit_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> code_o == {$past(wdata_i[HI_W-1:0]), $past(lo_q)});
  // R6
  stage_hidden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !hi_we_i) |=> $stable(code_o));
endmodule

// File: rtl/dac_dbuf_regs.sv
module dac_dbuf_regs
  import dac_dbuf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [CODE_W-1:0]  code0_o,
  output logic [CODE_W-1:0]  code1_o,
  output logic [N_CH-1:0]    commit_o
);
  logic [N_CH-1:0]   lo_we, hi_we;
  logic [CODE_W-1:0] code [N_CH];

  dac_addr_dec #(.NCH(N_CH)) u_dec (
    .wr_en_i(wr_en_i), .addr_i(addr_i), .lo_we_o(lo_we), .hi_we_o(hi_we)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dac_chan_latch u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .lo_we_i(lo_we[c]), .hi_we_i(hi_we[c]),
      .wdata_i(wdata_i), .code_o(code[c]), .commit_o(commit_o[c])
    );
  end

  assign code0_o = code[0];
  assign code1_o = code[1];

  // R2 R7
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lo_we, hi_we}));
  // R7
  ch1_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i inside {4'd4, 4'd5}) |=> $stable(code1_o));
  // R7
  ch0_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i inside {4'd6, 4'd7}) |=> $stable(code0_o));
  // R8
  pulse_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o != '0) |-> $onehot(commit_o));
endmodule

// File: tb/dac_dbuf_regs_bench.sv
module dac_dbuf_regs_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [11:0] code0, code1;
  logic [1:0]  commit;
  int checks = 0, errors = 0;
  logic [7:0]  m_lo [2];
  logic [11:0] m_code [2];
  logic [1:0]  m_commit;
  bit done = 0;

  always #10 clk = ~clk;

  dac_dbuf_regs u_dac_dbuf_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .code0_o(code0), .code1_o(code1), .commit_o(commit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, code0, m_code[0]);
    chk(req, code1, m_code[1]);
    chk(req, commit, m_commit);
  endtask

  // one write cycle, model updated, outputs checked after the edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    m_commit = 2'b00;
    for (int c = 0; c < 2; c++) begin
      if (a == 4'(5 + 2*c)) begin
        m_code[c] = {d[3:0], m_lo[c]};
        m_commit[c] = 1'b1;
      end
    end
    for (int c = 0; c < 2; c++)
      if (a == 4'(4 + 2*c)) m_lo[c] = d;
    @(negedge clk);
    wr_en = 0;
    check_all(req);
    m_commit = 2'b00;
    @(negedge clk);
    check_all({req, " pulse end"});
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_lo[0] = 0; m_lo[1] = 0; m_code[0] = 0; m_code[1] = 0; m_commit = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release");
    // R1: a commit right after reset shows the staged byte is zero
    wr(4'd5, 8'h0A, "R1 staged zero ch0");
    wr(4'd7, 8'h03, "R1 staged zero ch1");
    // R2 R3 R4: order low then high
    wr(4'd4, 8'h5C, "R3 stage ch0");
    wr(4'd5, 8'hF7, "R4 commit ch0 upper bits ignored");
    chk("R4 value", code0, 12'h75C);
    wr(4'd6, 8'hA1, "R3 stage ch1");
    wr(4'd7, 8'h0B, "R4 commit ch1");
    chk("R4 value ch1", code1, 12'hBA1);
    // R5: high byte only reuses the old low byte
    wr(4'd5, 8'h02, "R5 reuse ch0");
    chk("R5 value", code0, 12'h25C);
    // R6: low after high stays hidden
    wr(4'd4, 8'h33, "R6 late low ch0");
    chk("R6 hidden", code0, 12'h25C);
    wr(4'd5, 8'h09, "R6 next commit ch0");
    chk("R6 shown", code0, 12'h933);
    // R2 R7: sweep all addresses with several patterns
    for (int p = 0; p < 6; p++) begin
      for (int a = 0; a < 16; a++) begin
        logic [7:0] d;
        d = 8'((p * 8'h3B) ^ (a * 8'h11) ^ 8'hC6);
        wr(4'(a), d, "R2 R7 sweep");
      end
    end
    // R8: back-to-back commits on alternating channels
    @(negedge clk);
    wr_en = 1; addr = 4'd5; wdata = 8'h01;
    @(negedge clk);
    addr = 4'd7; wdata = 8'h02;
    m_code[0] = {4'h1, m_lo[0]};
    chk("R8 ch0 updated", code0, m_code[0]);
    chk("R8 pulse ch0", commit, 2'b01);
    @(negedge clk);
    wr_en = 0;
    m_code[1] = {4'h2, m_lo[1]};
    chk("R8 ch1 updated", code1, m_code[1]);
    chk("R8 pulse ch1", commit, 2'b10);
    @(negedge clk);
    chk("R8 pulse cleared", commit, 2'b00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule